// File: doc/BRIEF.md
# Page write buffer and cycle timer

This block sits behind the serial protocol engine of a small byte-wide nonvolatile store. When a write transaction opens, the engine hands it a start address. The engine then pushes each received data byte. The block gathers those bytes in a 16-entry page buffer, with one valid bit per entry. When the engine reports the stop condition, the block commits only the received entries to a 2048x8 array. The write address keeps the page bits of the start address, and the low offset bits come from the buffer index.

After a commit the block holds a busy flag for a fixed number of clock cycles, `WR_CYCLES`. This emulates the internal programming time. While busy is high, every request from the engine is ignored. The block also keeps the shared word pointer, which it advances to the address that follows the last byte received.

A byte offered while write protect is high is refused and blocks the commit. An abort (repeated start) or a reset drops the buffered data. A read port on the array lets the engine, or a bench, fetch stored bytes.

Top module: `page_commit_unit`

## Requirements
- R1: After reset, `busy` is 0 and `word_ptr` is 0. A reset in the middle of a transaction discards the collected bytes, so a later stop writes nothing.
- R2: A start stores the start address. The first pushed byte goes to that address, and each further byte goes to the next offset of the same page.
- R3: The in-page offset is the low 4 bits of the address and wraps from 15 to 0 without changing the page. When more than 16 bytes are pushed, the later bytes overwrite the earlier ones, and the last byte pushed to a given offset is the one that gets stored.
- R4: Only offsets that received a byte are written at commit. Every other byte of the page keeps its earlier value.
- R5: Nothing reaches the array before the stop. The array still returns the old data while a transaction is open. `busy` reads 1 in the cycle that follows the stop strobe.
- R6: After a commit, `busy` stays high for exactly `WR_CYCLES` cycles. Start, byte, stop and abort strobes offered during that time change neither the array nor the busy length.
- R7: If any byte of the transaction arrives while `wprot` is 1, the byte is not stored and the stop starts no write cycle. `busy` stays 0, and both the array and `word_ptr` keep their values.
- R8: An abort during an open transaction discards the collected bytes. A following stop writes nothing and does not raise `busy`.
- R9: At commit, `word_ptr` becomes the page of the start address joined with the offset after the last byte received (mod 16). It then stays unchanged until the next commit.
- R10: A stop that follows a start with no data bytes starts no write cycle.
- R11: `rd_data` returns the array byte at `rd_addr` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wprot | input | 1 | Write protect level, sampled with each pushed byte |
| start_vld | input | 1 | Opens a write transaction |
| start_addr | input | 11 | Start address (page and offset) for the transaction |
| byte_vld | input | 1 | A data byte is pushed this cycle |
| byte_data | input | 8 | Pushed data byte |
| stop_strobe | input | 1 | Stop condition; commits the transaction |
| abort_txn | input | 1 | Repeated start; discards the open transaction |
| busy | output | 1 | Internal write cycle in progress |
| word_ptr | output | 11 | Shared word pointer after the last commit |
| rd_addr | input | 11 | Array read address |
| rd_data | output | 8 | Array read data, one cycle latency |

## Verification
Some properties are checked on every cycle. A write strobe to the array appears only while busy is high. A commit always raises busy on the next cycle. The write timer stays within its range, and busy drops right after the timer reaches zero. The offset advances by one on every push, and the pushed offset gets marked valid. The word pointer holds steady for the whole busy period.

Other properties only the bench scenarios can show. These are the values that land in each page after wrapping, partial and overlapping transactions. They also include the untouched neighbours of a partial write, the exact busy length while strobes keep arriving, and the null effect of protect, abort, mid-transaction reset and empty stops. The bench compares all of these with a reference model of the array.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  // Commit sequencer states
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,  // accepting transactions
    SEQ_SCAN = 2'd1,  // walking the page buffer into the array
    SEQ_HOLD = 2'd2   // waiting out the remaining write time
  } seq_state_t;
endpackage

// File: rtl/pcu_page_buffer.sv
module pcu_page_buffer #(
  parameter int PAGE_BYTES = 16,
  parameter int DATA_W     = 8,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [OFF_W-1:0]      load_off,
  input  logic                  push,
  input  logic [DATA_W-1:0]     push_data,
  input  logic [OFF_W-1:0]      rd_idx,
  output logic [DATA_W-1:0]     rd_data,
  output logic [PAGE_BYTES-1:0] valid_mask,
  output logic [OFF_W-1:0]      cur_off
);

  logic [DATA_W-1:0] slot [PAGE_BYTES];

  // Data storage: no reset, written only on push
  always_ff @(posedge clk) begin
    if (push) slot[cur_off] <= push_data;
  end

  assign rd_data = slot[rd_idx];

  // Per-entry valid bits
  always_ff @(posedge clk) begin
    if (rst)       valid_mask <= '0;
    else if (load) valid_mask <= '0;
    else if (push) valid_mask[cur_off] <= 1'b1;
  end

  // In-page offset; natural wrap of OFF_W bits keeps it inside the page
  always_ff @(posedge clk) begin
    if (rst)       cur_off <= '0;
    else if (load) cur_off <= load_off;
    else if (push) cur_off <= cur_off + OFF_W'(1);
  end

  AST_OFF_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    push |=> cur_off == $past(cur_off) + OFF_W'(1)); // R3
  AST_MASK_MARK: assert property (@(posedge clk) disable iff (rst)
    push |=> valid_mask[$past(cur_off)]); // R4

endmodule

// File: rtl/pcu_write_seq.sv
module pcu_write_seq
  import pcu_pkg::*;
#(
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 40,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int TMR_W     = $clog2(WR_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_vld,
  input  logic             byte_vld,
  input  logic             stop_strobe,
  input  logic             abort_txn,
  input  logic             wprot,
  input  logic             mask_any,
  output logic             busy,
  output logic             load,
  output logic             push,
  output logic             commit,
  output logic             scan_en,
  output logic [OFF_W-1:0] scan_idx
);

  seq_state_t       state;
  logic             active;
  logic             refused;
  logic [TMR_W-1:0] timer;
  logic             idle;

  assign idle = (state == SEQ_IDLE);

  // Request decode; priority abort > start > stop > byte
  assign load   = idle & start_vld & ~abort_txn;
  assign push   = idle & active & byte_vld & ~wprot & ~start_vld
                & ~abort_txn & ~stop_strobe;
  assign commit = idle & active & stop_strobe & ~start_vld & ~abort_txn
                & ~refused & mask_any;
  assign scan_en = (state == SEQ_SCAN);

  // Transaction bookkeeping
  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      refused <= 1'b0;
    end else if (idle) begin
      if (abort_txn) begin
        active <= 1'b0;
      end else if (start_vld) begin
        active  <= 1'b1;
        refused <= 1'b0;
      end else if (stop_strobe) begin
        active <= 1'b0;
      end else if (active && byte_vld && wprot) begin
        refused <= 1'b1;
      end
    end
  end

  // Commit scan and write timer
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SEQ_IDLE;
      timer    <= '0;
      scan_idx <= '0;
      busy     <= 1'b0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (commit) begin
            state    <= SEQ_SCAN;
            scan_idx <= '0;
            timer    <= TMR_W'(WR_CYCLES - 1);
            busy     <= 1'b1;
          end
        end
        SEQ_SCAN: begin
          timer    <= timer - TMR_W'(1);
          scan_idx <= scan_idx + OFF_W'(1);
          if (scan_idx == OFF_W'(PAGE_BYTES - 1)) state <= SEQ_HOLD;
        end
        SEQ_HOLD: begin
          if (timer == '0) begin
            state <= SEQ_IDLE;
            busy  <= 1'b0;
          end else begin
            timer <= timer - TMR_W'(1);
          end
        end
        default: begin
          state <= SEQ_IDLE;
          busy  <= 1'b0;
        end
      endcase
    end
  end

  AST_COMMIT_BUSY: assert property (@(posedge clk) disable iff (rst)
    commit |=> busy); // R5
  AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy |-> timer <= TMR_W'(WR_CYCLES - 1)); // R6
  AST_BUSY_END: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_HOLD && timer == '0) |=> !busy); // R6
  AST_NO_PUSH_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !push && !load); // R6

endmodule

// File: rtl/pcu_mem_array.sv
module pcu_mem_array #(
  parameter int DEPTH  = 2048,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] cells [DEPTH];

  // Simple dual-port RAM with registered read
  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end

endmodule

// File: rtl/page_commit_unit.sv
module page_commit_unit #(
  parameter int MEM_BYTES  = 2048,
  parameter int PAGE_BYTES = 16,
  parameter int DATA_W     = 8,
  parameter int WR_CYCLES  = 40,
  localparam int ADDR_W    = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wprot,
  input  logic              start_vld,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop_strobe,
  input  logic              abort_txn,
  output logic              busy,
  output logic [ADDR_W-1:0] word_ptr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;

  logic                  load, push, commit, scan_en;
  logic [OFF_W-1:0]      scan_idx, cur_off;
  logic [PAGE_BYTES-1:0] valid_mask;
  logic [DATA_W-1:0]     slot_data;
  logic [PAGE_W-1:0]     page_q;
  logic                  mem_we;
  logic [ADDR_W-1:0]     mem_waddr;

  pcu_write_seq #(
    .PAGE_BYTES (PAGE_BYTES),
    .WR_CYCLES  (WR_CYCLES)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start_vld   (start_vld),
    .byte_vld    (byte_vld),
    .stop_strobe (stop_strobe),
    .abort_txn   (abort_txn),
    .wprot       (wprot),
    .mask_any    (|valid_mask),
    .busy        (busy),
    .load        (load),
    .push        (push),
    .commit      (commit),
    .scan_en     (scan_en),
    .scan_idx    (scan_idx)
  );

  pcu_page_buffer #(
    .PAGE_BYTES (PAGE_BYTES),
    .DATA_W     (DATA_W)
  ) u_buf (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .load_off   (start_addr[OFF_W-1:0]),
    .push       (push),
    .push_data  (byte_data),
    .rd_idx     (scan_idx),
    .rd_data    (slot_data),
    .valid_mask (valid_mask),
    .cur_off    (cur_off)
  );

  // Page number of the open transaction
  always_ff @(posedge clk) begin
    if (rst)       page_q <= '0;
    else if (load) page_q <= start_addr[ADDR_W-1:OFF_W];
  end

  // Shared word pointer, updated at commit
  always_ff @(posedge clk) begin
    if (rst)         word_ptr <= '0;
    else if (commit) word_ptr <= {page_q, cur_off};
  end

  assign mem_we    = scan_en & valid_mask[scan_idx];
  assign mem_waddr = {page_q, scan_idx};

  pcu_mem_array #(
    .DEPTH  (MEM_BYTES),
    .DATA_W (DATA_W)
  ) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (slot_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy); // R5
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(word_ptr)); // R9
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    busy |-> $stable(page_q)); // R4

endmodule

// File: tb/sim_page_commit_unit.sv
module sim_page_commit_unit;
  localparam int AW  = 11;
  localparam int WRC = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wprot = 1'b0, start_vld = 1'b0, byte_vld = 1'b0;
  logic stop_strobe = 1'b0, abort_txn = 1'b0;
  logic [AW-1:0] start_addr = '0, rd_addr = '0;
  logic [7:0] byte_data = '0;
  logic busy;
  logic [AW-1:0] word_ptr;
  logic [7:0] rd_data;

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] ref_mem [64];
  int ref_ptr = 0;

  page_commit_unit #(.MEM_BYTES(2048), .PAGE_BYTES(16), .DATA_W(8), .WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst(rst), .wprot(wprot), .start_vld(start_vld), .start_addr(start_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .stop_strobe(stop_strobe),
    .abort_txn(abort_txn), .busy(busy), .word_ptr(word_ptr), .rd_addr(rd_addr),
    .rd_data(rd_data));

  always #4 clk = ~clk;

  always @(negedge clk) begin
    cycles++;
    if (cycles >= 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic send_start(input int a);
    start_vld = 1'b1; start_addr = AW'(a); tick(); start_vld = 1'b0;
  endtask

  task automatic send_byte(input int d);
    byte_vld = 1'b1; byte_data = 8'(d); tick(); byte_vld = 1'b0;
  endtask

  task automatic pulse_stop();
    stop_strobe = 1'b1; tick(); stop_strobe = 1'b0;
  endtask

  task automatic pulse_abort();
    abort_txn = 1'b1; tick(); abort_txn = 1'b0;
  endtask

  function automatic int busy_len_count_step(input int n);
    return busy ? n + 1 : n;
  endfunction

  task automatic count_busy(inout int n);
    int guard = 0;
    while (busy && guard < 1000) begin
      n++; guard++; tick();
    end
  endtask

  task automatic check_page(input int pg, input string req);
    for (int i = 0; i < 16; i++) begin
      rd_addr = AW'(pg * 16 + i);
      tick();
      check(req, int'(rd_data), int'(ref_mem[pg * 16 + i]));
    end
  endtask

  // kind: 0 commit, 1 abort then stop, 2 write protected
  task automatic run_txn(input int pg, input int off, input int n, input int kind, input string req);
    int b;
    send_start(pg * 16 + off);
    for (int k = 0; k < n; k++) begin
      int d = int'($urandom_range(255, 0));
      wprot = (kind == 2);
      send_byte(d);
      if (kind == 0) ref_mem[pg * 16 + ((off + k) % 16)] = 8'(d);
    end
    wprot = 1'b0;
    if (kind == 1) pulse_abort();
    pulse_stop();
    if (kind == 0 && n > 0) begin
      b = 0;
      count_busy(b);
      check({req, " busy length"}, b, WRC);
      ref_ptr = pg * 16 + ((off + n) % 16);
    end else begin
      check({req, " no busy"}, int'(busy), 0);
    end
    check({req, " pointer"}, int'(word_ptr), ref_ptr);
    check_page(pg, req);
  endtask

  initial begin
    int n;
    void'($urandom(32'd2024));
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    check("R1 busy after reset", int'(busy), 0);
    check("R1 pointer after reset", int'(word_ptr), 0);

    // R2 full-page prefill, R11 read-back of every byte
    for (int pg = 0; pg < 4; pg++) run_txn(pg, 0, 16, 0, "R2 R11 prefill");

    // R4 partial write keeps neighbours
    run_txn(1, 5, 3, 0, "R4 partial");
    // R3 wrap with overwrite (20 bytes from offset 14)
    run_txn(2, 14, 20, 0, "R3 wrap overwrite");
    // R3 R9 wrap from offset 15
    run_txn(3, 15, 2, 0, "R3 R9 edge wrap");

    // R5 nothing written before stop
    send_start(16);
    send_byte(int'(~ref_mem[16]));
    rd_addr = AW'(16);
    tick();
    check("R5 old data while open", int'(rd_data), int'(ref_mem[16]));
    check("R5 not busy before stop", int'(busy), 0);
    ref_mem[16] = ~ref_mem[16];
    pulse_stop();
    check("R5 busy after stop", int'(busy), 1);
    n = 0;
    count_busy(n);
    ref_ptr = 17;
    check_page(1, "R5 committed");

    // R6 strobes during busy are ignored
    send_start(0);
    send_byte(8'h5A);
    ref_mem[0] = 8'h5A;
    pulse_stop();
    n = 0;
    n = busy_len_count_step(n); tick();
    n = busy_len_count_step(n); start_vld = 1'b1; start_addr = AW'(48); tick(); start_vld = 1'b0;
    n = busy_len_count_step(n); byte_vld = 1'b1; byte_data = 8'h3C; tick(); byte_vld = 1'b0;
    n = busy_len_count_step(n); abort_txn = 1'b1; tick(); abort_txn = 1'b0;
    n = busy_len_count_step(n); stop_strobe = 1'b1; tick(); stop_strobe = 1'b0;
    count_busy(n);
    check("R6 busy length with strobes", n, WRC);
    tick();
    check("R6 stop while busy ignored", int'(busy), 0);
    ref_ptr = 1;
    check("R6 pointer", int'(word_ptr), ref_ptr);
    check_page(3, "R6 page untouched");
    check_page(0, "R6 committed page");

    // R7 write protect
    run_txn(2, 4, 5, 2, "R7 protected");
    // R8 abort
    run_txn(3, 0, 6, 1, "R8 abort");
    // R10 empty transaction
    run_txn(0, 9, 0, 0, "R10 empty stop");

    // R1 reset in mid-transaction discards data
    send_start(32 + 3);
    send_byte(8'h11);
    send_byte(8'h22);
    rst = 1'b1; tick(); rst = 1'b0;
    pulse_stop();
    check("R1 no busy after reset discard", int'(busy), 0);
    ref_ptr = 0;
    check("R1 pointer cleared", int'(word_ptr), 0);
    check_page(2, "R1 page untouched");

    // Random mix: R2 R3 R4 R7 R8 R9
    for (int t = 0; t < 40; t++) begin
      int pg   = int'($urandom_range(3, 0));
      int off  = int'($urandom_range(15, 0));
      int cnt  = int'($urandom_range(20, 1));
      int r    = int'($urandom_range(9, 0));
      int kind = (r < 6) ? 0 : ((r < 8) ? 1 : 2);
      run_txn(pg, off, cnt, kind, "R2 R3 R4 R7 R8 R9 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule